// File: doc/BRIEF.md
# Wakeup Interrupt Trigger Normaliser

This block sits in front of a downstream interrupt controller that can only sense active-high levels and rising edges. It takes a bank of asynchronous wakeup interrupt pins and synchronises each one. It then applies a per-pin trigger type in hardware, so that active-low levels, falling edges and dual edges all reach the downstream side in a form it can sense.

Software programs each pin through a 32-bit word-wide register port. A bank of enable words holds one bit per pin. A separate configuration word per pin holds a 3-bit trigger code. The code is decoded into one of six modes. The mode OFF covers undefined codes. LVL_HI and LVL_LO pass the level straight through or inverted. RISE, FALL and BOTH produce a one-cycle pulse on the selected transitions. Each pin output is registered and gated by that pin's enable bit.

Top module: `irq_polarity_conv`

## Requirements
- R1: After reset every enable bit is 0, every pin's configuration code is 100, every pin output is 0 and the read data is 0.
- R2: Pin n is enabled by bit (n mod 32) of the enable word at byte address 0x10 + 4*(n/32). A write to one enable word changes only the pins of that word.
- R3: Pin n's trigger code sits in bits [2:0] of the word at byte address 0x110 + 4*n. A read returns the stored code with bits [31:3] as 0, whatever was written there.
- R4: Reads of enable bits for pins at or above NUM_PINS, reads of configuration words for such pins (with the default 126 pins, pins 126 and 127), and reads of any other address return 0. Writes to them have no effect.
- R5: While a pin's enable bit is 0 its output is 0, whatever its input does.
- R6: Code 100 (active-high level) drives the output with the synchronised input. An input change sampled at clock edge k appears on the output after edge k+2.
- R7: Code 000 (active-low level) drives the output with the inverse of the synchronised input, with the same latency as R6.
- R8: Code 110 (rising edge) gives a one-cycle high pulse for each low-to-high input transition, with the same latency as R6.
- R9: Code 010 (falling edge) gives a one-cycle high pulse for each high-to-low input transition.
- R10: Code 111 (dual edge) gives a one-cycle high pulse for each input transition in either direction.
- R11: Codes 001, 011 and 101 hold the pin output at 0.
- R12: Read data is loaded at the clock edge at which the read strobe is sampled high, and holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Raw asynchronous interrupt pins |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_PINS | Normalised active-high level or rising-pulse outputs |

## Verification
The bench drives one pin at a time through all eight codes, on pins at both ends of each enable word. It checks the output every cycle against a model that uses the input two and three edges back. If the synchroniser depth were off by one, or a falling edge were detected as a rising one, every transition in the pattern would miscompare. A pulse that lasted more than one cycle would also show, because the pattern includes back-to-back toggles. The bench also clears one enable bit while a neighbour in the same word stays on. A design that zeroed the whole word would drop the neighbour. Reads of configuration words just past the last pin and of unmapped enable words must return 0, so a decoder that aliases addresses shows up as nonzero data.

// File: rtl/irq_polarity_conv_pkg.sv
package irq_polarity_conv_pkg;

    // Trigger codes; the encoding is fixed by the software view.
    localparam logic [2:0] CODE_LVL_LO = 3'b000;
    localparam logic [2:0] CODE_FALL   = 3'b010;
    localparam logic [2:0] CODE_LVL_HI = 3'b100;
    localparam logic [2:0] CODE_RISE   = 3'b110;
    localparam logic [2:0] CODE_BOTH   = 3'b111;

    typedef enum logic [2:0] {
        TM_OFF,
        TM_LVL_HI,
        TM_LVL_LO,
        TM_RISE,
        TM_FALL,
        TM_BOTH
    } trig_mode_e;

    function automatic trig_mode_e decode_mode(input logic [2:0] code);
        trig_mode_e m;
        case (code)
            CODE_LVL_LO: m = TM_LVL_LO;
            CODE_FALL:   m = TM_FALL;
            CODE_LVL_HI: m = TM_LVL_HI;
            CODE_RISE:   m = TM_RISE;
            CODE_BOTH:   m = TM_BOTH;
            default:     m = TM_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ipc_sync.sv
module ipc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/ipc_regs.sv
module ipc_regs #(
    parameter int NUM_PINS = 126,
    parameter int ADDR_W   = 12,
    parameter int EN_BASE  = 'h10,
    parameter int CFG_BASE = 'h110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output logic [NUM_PINS-1:0]   en_vec,
    output logic [3*NUM_PINS-1:0] cfg_flat
);

    import irq_polarity_conv_pkg::*;

    localparam int          NUM_WORDS = (NUM_PINS + 31) / 32;
    localparam logic [31:0] EN_LO     = 32'(EN_BASE);
    localparam logic [31:0] EN_HI     = 32'(EN_BASE + 4 * NUM_WORDS);
    localparam logic [31:0] CFG_LO    = 32'(CFG_BASE);
    localparam logic [31:0] CFG_HI    = 32'(CFG_BASE + 4 * NUM_PINS);

    logic [NUM_PINS-1:0] en_q;
    logic [2:0]          cfg_q [NUM_PINS];
    logic [31:0]         addr32;
    logic                en_hit;
    logic                cfg_hit;
    logic [31:0]         en_idx;
    logic [31:0]         cfg_idx;
    logic [31:0]         rd_next;

    assign addr32  = 32'(addr);
    assign en_hit  = (addr32 >= EN_LO) && (addr32 < EN_HI);
    assign cfg_hit = (addr32 >= CFG_LO) && (addr32 < CFG_HI);
    assign en_idx  = (addr32 - EN_LO) >> 2;
    assign cfg_idx = (addr32 - CFG_LO) >> 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            rdata <= '0;
            for (int p = 0; p < NUM_PINS; p++) begin
                cfg_q[p] <= CODE_LVL_HI;
            end
        end else begin
            if (wr_en && en_hit) begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (32'(p / 32) == en_idx) begin
                        en_q[p] <= wdata[p % 32];
                    end
                end
            end
            if (wr_en && cfg_hit) begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (32'(p) == cfg_idx) begin
                        cfg_q[p] <= wdata[2:0];
                    end
                end
            end
            if (rd_en) begin
                rdata <= rd_next;
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (en_hit) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (32'(p / 32) == en_idx) begin
                    rd_next[p % 32] = en_q[p];
                end
            end
        end else if (cfg_hit) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (32'(p) == cfg_idx) begin
                    rd_next[2:0] = cfg_q[p];
                end
            end
        end
    end

    assign en_vec = en_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cfg_flat
        assign cfg_flat[3*g +: 3] = cfg_q[g];
    end

endmodule

// File: rtl/ipc_pin.sv
module ipc_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       en,
    input  logic [2:0] code,
    output logic       irq
);

    import irq_polarity_conv_pkg::*;

    trig_mode_e mode;
    logic       prev_lvl;
    logic       hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
        end else begin
            prev_lvl <= lvl;
        end
    end

    always_comb begin
        mode = decode_mode(code);
        unique case (mode)
            TM_LVL_HI: hit = lvl;
            TM_LVL_LO: hit = !lvl;
            TM_RISE:   hit = lvl && !prev_lvl;
            TM_FALL:   hit = !lvl && prev_lvl;
            TM_BOTH:   hit = lvl ^ prev_lvl;
            TM_OFF:    hit = 1'b0;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= en && hit;
        end
    end

endmodule

// File: rtl/irq_polarity_conv.sv
module irq_polarity_conv #(
    parameter int NUM_PINS = 126,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_PINS-1:0] irq_out
);

    logic [NUM_PINS-1:0]   sync_lvl;
    logic [NUM_PINS-1:0]   en_vec;
    logic [3*NUM_PINS-1:0] cfg_flat;

    ipc_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    ipc_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .EN_BASE  ('h10),
        .CFG_BASE ('h110)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .en_vec   (en_vec),
        .cfg_flat (cfg_flat)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        ipc_pin u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (sync_lvl[g]),
            .en    (en_vec[g]),
            .code  (cfg_flat[3*g +: 3]),
            .irq   (irq_out[g])
        );
    end

endmodule

// File: rtl/irq_polarity_conv_chk.sv
module irq_polarity_conv_chk #(
    parameter int NUM_PINS = 126
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   sync_lvl,
    input logic [NUM_PINS-1:0]   en_vec,
    input logic [3*NUM_PINS-1:0] cfg_flat,
    input logic [NUM_PINS-1:0]   irq_out
);

    // R5: no output is high unless its enable was set for the computing edge
    assert_gated_by_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~$past(en_vec)) == '0);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R6: active-high level follows the synchronised input
        assert_level_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_vec[i]) && $past(cfg_flat[3*i +: 3]) == 3'b100)
            |-> irq_out[i] == $past(sync_lvl[i]));

        // R7: active-low level is inverted
        assert_level_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_vec[i]) && $past(cfg_flat[3*i +: 3]) == 3'b000)
            |-> irq_out[i] == !$past(sync_lvl[i]));

        // R8: a rising-mode pulse needs a low-to-high synchronised transition
        assert_rise_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[i] && $past(cfg_flat[3*i +: 3]) == 3'b110)
            |-> ($past(sync_lvl[i]) && !$past(sync_lvl[i], 2)));

        // R11: undefined codes keep the output low
        assert_undef_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cfg_flat[3*i +: 3]) == 3'b001 || $past(cfg_flat[3*i +: 3]) == 3'b011 ||
             $past(cfg_flat[3*i +: 3]) == 3'b101) |-> !irq_out[i]);
    end

endmodule

bind irq_polarity_conv irq_polarity_conv_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_lvl (sync_lvl),
    .en_vec   (en_vec),
    .cfg_flat (cfg_flat),
    .irq_out  (irq_out)
);

// File: tb/irq_polarity_conv_bench.sv
module irq_polarity_conv_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          NPINS      = 40;
    localparam int          EN_BASE    = 'h10;
    localparam int          CFG_BASE   = 'h110;
    localparam int          PLEN       = 48;
    localparam logic [63:0] PAT        = 64'hB38F_0E1C_66D5_A3C9;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NPINS-1:0] pin_in;
    logic             reg_wr_en;
    logic             reg_rd_en;
    logic [11:0]      reg_addr;
    logic [31:0]      reg_wdata;
    logic [31:0]      reg_rdata;
    logic [NPINS-1:0] irq_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    logic hist [PLEN];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_polarity_conv #(
        .NUM_PINS (NPINS),
        .ADDR_W   (12)
    ) u_irq_polarity_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = 12'(addr);
        reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        reg_rd_en = 1'b1;
        reg_addr  = 12'(addr);
        @(negedge clk);
        data      = reg_rdata;
        reg_rd_en = 1'b0;
    endtask

    function automatic logic model(input logic [2:0] c, input logic s, input logic p);
        case (c)
            3'b000:  return !s;
            3'b100:  return s;
            3'b110:  return s && !p;
            3'b010:  return !s && p;
            3'b111:  return s ^ p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'b000:  return "R7";
            3'b100:  return "R6";
            3'b110:  return "R8";
            3'b010:  return "R9";
            3'b111:  return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic run_mode(input int pin, input logic [2:0] code);
        logic e;
        pin_in = '0;
        wr(CFG_BASE + 4*pin, {29'h0, code});
        wr(EN_BASE + 4*(pin/32), 32'(1) << (pin % 32));
        for (int j = 0; j < PLEN; j++) begin
            @(negedge clk);
            if (j >= 4) begin
                e = model(code, hist[j-3], hist[j-4]);
                chk(irq_out[pin] == e, req_of(code), 32'(irq_out[pin]), 32'(e));
                chk((irq_out & ~(NPINS'(1) << pin)) == '0, "R5 other pins",
                    32'(irq_out & ~(NPINS'(1) << pin)), 32'h0);
            end
            pin_in[pin] = hist[j];
        end
        // R5: once disabled, toggling the input does nothing
        wr(EN_BASE + 4*(pin/32), 32'h0);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk(irq_out[pin] == 1'b0, "R5", 32'(irq_out[pin]), 32'h0);
            pin_in[pin] = ~pin_in[pin];
        end
        pin_in = '0;
        wr(CFG_BASE + 4*pin, 32'h4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int          pins [4];
        pins[0] = 0; pins[1] = 31; pins[2] = 32; pins[3] = 39;
        for (int j = 0; j < PLEN; j++) hist[j] = (j < 4) ? 1'b0 : PAT[j];

        rst_n = 1'b0; pin_in = '0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(irq_out == '0, "R1 outputs", 32'(irq_out), 32'h0);
        chk(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
        rd(EN_BASE, d);      chk(d == 32'h0, "R1 enable word 0", d, 32'h0);
        rd(EN_BASE + 4, d);  chk(d == 32'h0, "R1 enable word 1", d, 32'h0);
        for (int p = 0; p < NPINS; p++) begin
            rd(CFG_BASE + 4*p, d);
            chk(d == 32'h4, "R1 config reset", d, 32'h4);
        end

        // R3: config storage, upper bits read as zero
        for (int p = 0; p < NPINS; p++) wr(CFG_BASE + 4*p, 32'hFFFF_FFF8 | 32'((p*3) & 7));
        for (int p = 0; p < NPINS; p++) begin
            rd(CFG_BASE + 4*p, d);
            chk(d == 32'((p*3) & 7), "R3", d, 32'((p*3) & 7));
        end

        // R2 / R4: enable words and unmapped space
        wr(EN_BASE, 32'hFFFF_FFFF);
        wr(EN_BASE + 4, 32'hFFFF_FFFF);
        rd(EN_BASE, d);      chk(d == 32'hFFFF_FFFF, "R2 word 0", d, 32'hFFFF_FFFF);
        rd(EN_BASE + 4, d);  chk(d == 32'h0000_00FF, "R4 bits above last pin", d, 32'hFF);
        wr(EN_BASE + 8, 32'hFFFF_FFFF);
        rd(EN_BASE + 8, d);  chk(d == 32'h0, "R4 unmapped enable word", d, 32'h0);
        wr(CFG_BASE + 4*NPINS, 32'h7);
        rd(CFG_BASE + 4*NPINS, d); chk(d == 32'h0, "R4 config past last pin", d, 32'h0);
        rd(CFG_BASE - 4, d); chk(d == 32'h0, "R4 gap address", d, 32'h0);

        // R12: read data holds while strobe is low
        rd(EN_BASE + 4, d);
        wr(EN_BASE + 4, 32'h0000_000F);
        @(negedge clk);
        chk(reg_rdata == 32'hFF, "R12 hold", reg_rdata, 32'hFF);
        rd(EN_BASE + 4, d);  chk(d == 32'h0F, "R12 new read", d, 32'h0F);

        // restore defaults
        wr(EN_BASE, 32'h0);
        wr(EN_BASE + 4, 32'h0);
        for (int p = 0; p < NPINS; p++) wr(CFG_BASE + 4*p, 32'h4);
        repeat (3) @(negedge clk);
        chk(irq_out == '0, "R5 all disabled", 32'(irq_out), 32'h0);

        // R2: per-bit enable, neighbours untouched
        pin_in[5] = 1'b1; pin_in[6] = 1'b1; pin_in[37] = 1'b1;
        wr(EN_BASE, (32'h1 << 5) | (32'h1 << 6));
        repeat (3) @(negedge clk);
        chk(irq_out[6:5] == 2'b11, "R2 both on", 32'(irq_out[6:5]), 32'h3);
        chk(irq_out[37] == 1'b0, "R2 pin 37 off", 32'(irq_out[37]), 32'h0);
        wr(EN_BASE, 32'h1 << 6);
        repeat (2) @(negedge clk);
        chk(irq_out[6:5] == 2'b10, "R2 only bit 5 cleared", 32'(irq_out[6:5]), 32'h2);
        wr(EN_BASE + 4, 32'h1 << 5);
        repeat (2) @(negedge clk);
        chk(irq_out[37] == 1'b1, "R2 pin 37 via word 1", 32'(irq_out[37]), 32'h1);
        chk(irq_out[5] == 1'b0, "R2 word 1 leaves pin 5", 32'(irq_out[5]), 32'h0);
        wr(EN_BASE, 32'h0);
        wr(EN_BASE + 4, 32'h0);
        pin_in = '0;

        // R6..R11: every code on pins at word edges
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 8; c++) begin
                run_mode(pins[k], 3'(c));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule